// File: doc/BRIEF.md
# Operand Address Generator for an 8-bit Processor Core

This block resolves the data operand of an instruction that has already been decoded. The core hands it an addressing-mode code, the one or two operand bytes that followed the opcode, the X and Y index registers, the accumulator value and, for a store, the byte to be written. The block works out the effective address. For the indirect modes it first fetches a two-byte pointer from page zero. It then performs exactly one data read or one data write on the memory bus. When the access is finished it gives a one-cycle `done` pulse.

The immediate and accumulator modes complete without any bus cycle. Jump-only modes, branch modes and the bit-test-and-branch mode carry no data operand, so the block rejects them with `err`, and it rejects a write to an immediate. The memory port is combinational: `mem_rdata` is taken in the same cycle as `mem_rd`. A start request is accepted only while the block is idle, and that includes the cycle in which `done` is high.

Top module: `opnd_agu`

## Requirements
- R1: While reset is held and after it is released, `done`, `err`, `mem_rd`, `mem_wr` and `acc_wr` are low and `rdata` is 0.
- R2: Immediate mode (mode 2) with `wr`=0 returns `op1` on `rdata`, with `done` high in the cycle after the start and no bus strobe.
- R3: Accumulator mode (mode 1) completes in the cycle after the start with no bus strobe. A read returns `acc_in` on `rdata`. A write (`wr`=1) pulses `acc_wr` together with `done`, with `acc_wdata` equal to `wdata`.
- R4: Page-zero modes use address {0x00, op1} for mode 3, {0x00, (op1+X) mod 256} for mode 4 and {0x00, (op1+Y) mod 256} for mode 5. The single data strobe falls in cycle 1 after the start, and `done` in cycle 2.
- R5: Absolute modes use {op2,op1} for mode 9, and {op2,op1}+X for mode 10 or {op2,op1}+Y for mode 11, each modulo 65536. The timing is the same as in R4.
- R6: Page-zero indirect mode (mode 6) reads the pointer low byte at {0x00,op1} in cycle 1 and the high byte at {0x00,(op1+1) mod 256} in cycle 2. It accesses data at the pointer in cycle 3, and `done` follows in cycle 4.
- R7: Pre-indexed indirect mode (mode 7) fetches the pointer at {0x00,(op1+X) mod 256} and then at {0x00,(op1+X+1) mod 256}, low byte first, and accesses data at that pointer. The timing is the same as in R6.
- R8: Post-indexed indirect mode (mode 8) fetches the pointer as in R6 and accesses data at (pointer+Y) mod 65536, so Y is added to the address and never to the data.
- R9: Modes 0, 12, 13, 14 and 15, and mode 2 with `wr`=1, raise `err` together with `done` in the cycle after the start, with no bus strobe and no `acc_wr`.
- R10: A write (`wr`=1) strobes `mem_wr` with `mem_wdata` equal to `wdata` in the data cycle and never asserts `mem_rd` in that cycle. `mem_rd` and `mem_wr` are never high together.
- R11: `rdata` changes only in a cycle where `done` is high, and a write leaves it unchanged. A start raised while an access is in progress is ignored. A start raised in the cycle where `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to resolve one operand, sampled when idle |
| mode | input | 4 | Addressing-mode code (see requirements) |
| wr | input | 1 | 1 = write the operand, 0 = read it |
| op1 | input | 8 | First operand byte |
| op2 | input | 8 | Second operand byte (high address byte) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| acc_in | input | 8 | Accumulator value for accumulator-mode reads |
| wdata | input | 8 | Byte to write |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the strobe cycle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Mode rejected, valid with `done` |
| rdata | output | 8 | Operand value of the last completed read |
| acc_wr | output | 1 | Accumulator load pulse |
| acc_wdata | output | 8 | Value to load into the accumulator |

## Verification
The completion of one operation and the acceptance of the next one can fall in the same cycle. The `done` cycle is also the first idle cycle, so a new start raised there must be taken while the finished result is still being presented. The bench provokes this by raising a page-zero read start in the exact cycle where an immediate read shows `done`. It judges the result by checking two things: the immediate value stays correct in that cycle, and the new access strobes the new address one cycle later. A companion test holds `start` high with different operands during a pointer fetch and checks that the fetch addresses and the result still come from the first request.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

  typedef enum logic [3:0] {
    AM_IMPL  = 4'd0,
    AM_ACC   = 4'd1,
    AM_IMM   = 4'd2,
    AM_ZP    = 4'd3,
    AM_ZPX   = 4'd4,
    AM_ZPY   = 4'd5,
    AM_IZP   = 4'd6,
    AM_IZPX  = 4'd7,
    AM_IZPY  = 4'd8,
    AM_ABS   = 4'd9,
    AM_ABSX  = 4'd10,
    AM_ABSY  = 4'd11,
    AM_IABS  = 4'd12,
    AM_IABSX = 4'd13,
    AM_REL   = 4'd14,
    AM_ZPREL = 4'd15
  } amode_e;

  // Service class of a request
  typedef enum logic [1:0] {
    CL_LOCAL    = 2'd0,  // served without the bus
    CL_DIRECT   = 2'd1,  // one data cycle
    CL_INDIRECT = 2'd2,  // two pointer cycles, then data
    CL_REJECT   = 2'd3   // no data operand
  } mclass_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PLO  = 2'd1,
    SQ_PHI  = 2'd2,
    SQ_DATA = 2'd3
  } seq_e;

endpackage

// File: rtl/opnd_mode_class.sv
module opnd_mode_class
  import opnd_pkg::*;
(
  input  amode_e  mode,
  input  logic    wr,
  output mclass_e cls
);

  always_comb begin
    unique case (mode)
      AM_ACC:                          cls = CL_LOCAL;
      AM_IMM:                          cls = wr ? CL_REJECT : CL_LOCAL;
      AM_ZP, AM_ZPX, AM_ZPY,
      AM_ABS, AM_ABSX, AM_ABSY:        cls = CL_DIRECT;
      AM_IZP, AM_IZPX, AM_IZPY:        cls = CL_INDIRECT;
      default:                         cls = CL_REJECT;
    endcase
  end

endmodule

// File: rtl/opnd_addr_calc.sv
module opnd_addr_calc
  import opnd_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  amode_e          mode,
  input  logic [DW-1:0]   op1,
  input  logic [DW-1:0]   op2,
  input  logic [DW-1:0]   ix,
  input  logic [DW-1:0]   iy,
  input  logic [AW-1:0]   ptr,
  output logic [AW-1:0]   ptr_lo_addr,
  output logic [AW-1:0]   ptr_hi_addr,
  output logic [AW-1:0]   data_addr
);

  localparam logic [DW-1:0] ONE_B   = DW'(1);
  localparam logic [DW-1:0] ZERO_PG = '0;

  logic [DW-1:0] zp_base;
  logic [DW-1:0] zp_x;
  logic [DW-1:0] zp_y;
  logic [AW-1:0] abs_base;

  // Page-zero sums are kept DW bits wide so that they wrap inside page zero
  always_comb begin
    zp_x     = op1 + ix;
    zp_y     = op1 + iy;
    zp_base  = (mode == AM_IZPX) ? zp_x : op1;
    abs_base = {op2, op1};
  end

  always_comb begin
    ptr_lo_addr = {ZERO_PG, zp_base};
    ptr_hi_addr = {ZERO_PG, zp_base + ONE_B};
  end

  always_comb begin
    unique case (mode)
      AM_ZP:            data_addr = {ZERO_PG, op1};
      AM_ZPX:           data_addr = {ZERO_PG, zp_x};
      AM_ZPY:           data_addr = {ZERO_PG, zp_y};
      AM_ABSX:          data_addr = abs_base + {ZERO_PG, ix};
      AM_ABSY:          data_addr = abs_base + {ZERO_PG, iy};
      AM_IZP, AM_IZPX:  data_addr = ptr;
      AM_IZPY:          data_addr = ptr + {ZERO_PG, iy};
      default:          data_addr = abs_base;
    endcase
  end

endmodule

// File: rtl/opnd_seq.sv
module opnd_seq
  import opnd_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  mclass_e       cls,
  input  logic          wr,
  input  logic          acc_sel,
  input  logic [DW-1:0] local_val,
  input  logic [DW-1:0] mem_rdata,
  output logic          accept,
  output seq_e          st,
  output logic [AW-1:0] ptr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          done,
  output logic          err,
  output logic          acc_wr,
  output logic [DW-1:0] rdata
);

  seq_e          st_q, st_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          accwr_q, accwr_d;

  always_comb begin
    accept = start && (st_q == SQ_IDLE);
  end

  // Next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (accept) begin
          if (cls == CL_DIRECT)        st_d = SQ_DATA;
          else if (cls == CL_INDIRECT) st_d = SQ_PLO;
          else                         st_d = SQ_IDLE;
        end
      end
      SQ_PLO:  st_d = SQ_PHI;
      SQ_PHI:  st_d = SQ_DATA;
      SQ_DATA: st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  // Datapath next values
  always_comb begin
    wr_d    = accept ? wr : wr_q;
    ptr_d   = ptr_q;
    rdata_d = rdata_q;
    if (st_q == SQ_PLO) ptr_d[DW-1:0]  = mem_rdata;
    if (st_q == SQ_PHI) ptr_d[AW-1:DW] = mem_rdata;
    if (accept && (cls == CL_LOCAL) && !wr)   rdata_d = local_val;
    if ((st_q == SQ_DATA) && !wr_q)           rdata_d = mem_rdata;
    done_d  = (accept && ((cls == CL_LOCAL) || (cls == CL_REJECT))) ||
              (st_q == SQ_DATA);
    err_d   = accept && (cls == CL_REJECT);
    accwr_d = accept && (cls == CL_LOCAL) && acc_sel && wr;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      wr_q    <= 1'b0;
      ptr_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      accwr_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      wr_q    <= wr_d;
      ptr_q   <= ptr_d;
      rdata_q <= rdata_d;
      done_q  <= done_d;
      err_q   <= err_d;
      accwr_q <= accwr_d;
    end
  end

  always_comb begin
    st     = st_q;
    ptr    = ptr_q;
    mem_rd = (st_q == SQ_PLO) || (st_q == SQ_PHI) || ((st_q == SQ_DATA) && !wr_q);
    mem_wr = (st_q == SQ_DATA) && wr_q;
    done   = done_q;
    err    = err_q;
    acc_wr = accwr_q;
    rdata  = rdata_q;
  end

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R10

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !acc_wr)); // R9

  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !$past(mem_rd || mem_wr)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata)); // R11

endmodule

// File: rtl/opnd_agu.sv
module opnd_agu
  import opnd_pkg::*;
#(
  parameter int DW         = 8,
  parameter int RST_STAGES = 2,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic          wr,
  input  logic [DW-1:0] op1,
  input  logic [DW-1:0] op2,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic          acc_wr,
  output logic [DW-1:0] acc_wdata
);

  localparam logic [DW-1:0] ONE_B = DW'(1);

  // Reset: asserted asynchronously, released through a synchronizer
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  generate
    if (RST_STAGES == 1) begin : g_rst_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end else begin : g_rst_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  amode_e        mode_in;
  mclass_e       cls_in;
  logic          accept;
  seq_e          st;
  logic [AW-1:0] ptr;
  logic [AW-1:0] ptr_lo_addr, ptr_hi_addr, data_addr;
  logic [DW-1:0] local_val;

  amode_e        mode_q;
  logic [DW-1:0] op1_q, op2_q, x_q, y_q, wdata_q;

  always_comb begin
    mode_in   = amode_e'(mode);
    local_val = (mode_in == AM_ACC) ? acc_in : op1;
  end

  opnd_mode_class u_class (
    .mode (mode_in),
    .wr   (wr),
    .cls  (cls_in)
  );

  // Operand capture, enabled by acceptance of a request
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q  <= AM_IMPL;
      op1_q   <= '0;
      op2_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      mode_q  <= mode_in;
      op1_q   <= op1;
      op2_q   <= op2;
      x_q     <= idx_x;
      y_q     <= idx_y;
      wdata_q <= wdata;
    end
  end

  opnd_addr_calc #(.DW(DW)) u_calc (
    .mode        (mode_q),
    .op1         (op1_q),
    .op2         (op2_q),
    .ix          (x_q),
    .iy          (y_q),
    .ptr         (ptr),
    .ptr_lo_addr (ptr_lo_addr),
    .ptr_hi_addr (ptr_hi_addr),
    .data_addr   (data_addr)
  );

  opnd_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .cls       (cls_in),
    .wr        (wr),
    .acc_sel   (mode_in == AM_ACC),
    .local_val (local_val),
    .mem_rdata (mem_rdata),
    .accept    (accept),
    .st        (st),
    .ptr       (ptr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .done      (done),
    .err       (err),
    .acc_wr    (acc_wr),
    .rdata     (rdata)
  );

  always_comb begin
    unique case (st)
      SQ_PLO:  mem_addr = ptr_lo_addr;
      SQ_PHI:  mem_addr = ptr_hi_addr;
      default: mem_addr = data_addr;
    endcase
    mem_wdata = wdata_q;
    acc_wdata = wdata_q;
  end

  AST_PTR_IN_PAGE0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((st == SQ_PLO) || (st == SQ_PHI)) |-> (mem_addr[AW-1:DW] == '0)); // R6

  AST_PTR_HI_NEXT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st == SQ_PHI) |-> (mem_addr[DW-1:0] == $past(mem_addr[DW-1:0]) + ONE_B)); // R7

  AST_ZPIDX_IN_PAGE0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((st == SQ_DATA) && ((mode_q == AM_ZP) || (mode_q == AM_ZPX) || (mode_q == AM_ZPY)))
    |-> (mem_addr[AW-1:DW] == '0)); // R4

endmodule

// File: tb/opnd_agu_tb.sv
`timescale 1ns/1ps
module opnd_agu_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  mode;
  logic        wr;
  logic [7:0]  op1, op2, idx_x, idx_y, acc_in, wdata;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        done, err, acc_wr;
  logic [7:0]  rdata, acc_wdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_rdata = memf(mem_addr);

  opnd_agu u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .wr(wr),
    .op1(op1), .op2(op2), .idx_x(idx_x), .idx_y(idx_y), .acc_in(acc_in),
    .wdata(wdata), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .err(err),
    .rdata(rdata), .acc_wr(acc_wr), .acc_wdata(acc_wdata)
  );

  // Trace of one operation, index = cycles after the start cycle
  logic        tr_rd [1:6];
  logic        tr_wr [1:6];
  logic [15:0] tr_addr [1:6];
  logic [7:0]  tr_wd [1:6];
  int          lat;
  logic        g_err, g_accwr;
  logic [7:0]  g_accwd, g_rdata;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int nstrobe();
    int n = 0;
    for (int k = 1; k <= 6; k++) if (tr_rd[k] || tr_wr[k]) n++;
    return n;
  endfunction

  task automatic do_op(input logic [3:0] m, input logic w, input logic [7:0] o1,
                       input logic [7:0] o2, input logic [7:0] xx, input logic [7:0] yy,
                       input logic [7:0] ac, input logic [7:0] wd);
    for (int k = 1; k <= 6; k++) begin
      tr_rd[k] = 0; tr_wr[k] = 0; tr_addr[k] = '0; tr_wd[k] = '0;
    end
    lat = 0; g_err = 0; g_accwr = 0; g_accwd = '0; g_rdata = '0;
    @(negedge clk);
    mode = m; wr = w; op1 = o1; op2 = o2; idx_x = xx; idx_y = yy;
    acc_in = ac; wdata = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      tr_rd[k] = mem_rd; tr_wr[k] = mem_wr; tr_addr[k] = mem_addr; tr_wd[k] = mem_wdata;
      if (done) begin
        lat = k; g_err = err; g_accwr = acc_wr; g_accwd = acc_wdata; g_rdata = rdata;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1", "done", done, 0);
    chk("R1", "err", err, 0);
    chk("R1", "mem strobes", {mem_rd, mem_wr}, 0);
    chk("R1", "acc_wr", acc_wr, 0);
    chk("R1", "rdata", rdata, 0);
  endtask

  task automatic t_imm();
    do_op(4'd2, 0, 8'hA7, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R2", "latency", lat, 1);
    chk("R2", "rdata", g_rdata, 8'hA7);
    chk("R2", "strobes", nstrobe(), 0);
    chk("R2", "err", g_err, 0);
  endtask

  task automatic t_acc();
    do_op(4'd1, 0, 8'h11, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h00);
    chk("R3", "read latency", lat, 1);
    chk("R3", "read value", g_rdata, 8'h3C);
    chk("R3", "read acc_wr", g_accwr, 0);
    do_op(4'd1, 1, 8'h11, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h81);
    chk("R3", "write acc_wr", g_accwr, 1);
    chk("R3", "write acc_wdata", g_accwd, 8'h81);
    chk("R3", "write strobes", nstrobe(), 0);
    chk("R11", "rdata kept by acc write", g_rdata, 8'h3C);
  endtask

  task automatic t_zp();
    do_op(4'd3, 0, 8'h44, 8'hEE, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R4", "zp latency", lat, 2);
    chk("R4", "zp strobe", tr_rd[1], 1);
    chk("R4", "zp addr", tr_addr[1], 16'h0044);
    chk("R4", "zp data", g_rdata, memf(16'h0044));
    do_op(4'd4, 0, 8'hF0, 8'hEE, 8'h20, 8'h00, 8'h00, 8'h00);
    chk("R4", "zpx wrap addr", tr_addr[1], 16'h0010);
    do_op(4'd5, 0, 8'hC5, 8'hEE, 8'h00, 8'h50, 8'h00, 8'h00);
    chk("R4", "zpy wrap addr", tr_addr[1], 16'h0015);
    chk("R4", "zpy strobes", nstrobe(), 1);
  endtask

  task automatic t_abs();
    do_op(4'd9, 0, 8'h34, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R5", "abs latency", lat, 2);
    chk("R5", "abs addr", tr_addr[1], 16'h1234);
    chk("R5", "abs data", g_rdata, memf(16'h1234));
    do_op(4'd10, 0, 8'hF0, 8'h12, 8'h30, 8'h00, 8'h00, 8'h00);
    chk("R5", "absx carry addr", tr_addr[1], 16'h1320);
    do_op(4'd11, 0, 8'hFF, 8'hFF, 8'h00, 8'h02, 8'h00, 8'h00);
    chk("R5", "absy wrap addr", tr_addr[1], 16'h0001);
  endtask

  task automatic t_indirect(input logic [3:0] m, input string req,
                            input logic [7:0] o1, input logic [7:0] xx, input logic [7:0] yy);
    logic [7:0]  base;
    logic [15:0] p, a;
    base = (m == 4'd7) ? o1 + xx : o1;
    p = {memf({8'h00, base + 8'h01}), memf({8'h00, base})};
    a = (m == 4'd8) ? p + {8'h00, yy} : p;
    do_op(m, 0, o1, 8'hEE, xx, yy, 8'h00, 8'h00);
    chk(req, "latency", lat, 4);
    chk(req, "ptr lo addr", {tr_rd[1], tr_addr[1]}, {1'b1, 8'h00, base});
    chk(req, "ptr hi addr", {tr_rd[2], tr_addr[2]}, {1'b1, 8'h00, base + 8'h01});
    chk(req, "data addr", {tr_rd[3], tr_addr[3]}, {1'b1, a});
    chk(req, "data", g_rdata, memf(a));
  endtask

  task automatic t_err();
    logic [3:0] bad [0:4];
    bad[0] = 4'd0; bad[1] = 4'd12; bad[2] = 4'd13; bad[3] = 4'd14; bad[4] = 4'd15;
    for (int i = 0; i <= 4; i++) begin
      do_op(bad[i], 0, 8'h22, 8'h33, 8'h01, 8'h01, 8'h00, 8'h00);
      chk("R9", "reject latency", lat, 1);
      chk("R9", "reject err", g_err, 1);
      chk("R9", "reject strobes", nstrobe(), 0);
    end
    do_op(4'd2, 1, 8'h22, 8'h00, 8'h00, 8'h00, 8'h00, 8'h55);
    chk("R9", "imm write err", g_err, 1);
    chk("R9", "imm write acc_wr", g_accwr, 0);
  endtask

  task automatic t_write();
    logic [15:0] p;
    do_op(4'd2, 0, 8'h6D, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    do_op(4'd3, 1, 8'h70, 8'h00, 8'h00, 8'h00, 8'h00, 8'h99);
    chk("R10", "zp write strobes", {tr_wr[1], tr_rd[1]}, 2'b10);
    chk("R10", "zp write addr", tr_addr[1], 16'h0070);
    chk("R10", "zp write data", tr_wd[1], 8'h99);
    chk("R11", "rdata kept by write", g_rdata, 8'h6D);
    p = {memf(16'h0009), memf(16'h0008)} + 16'h0004;
    do_op(4'd8, 1, 8'h08, 8'h00, 8'h00, 8'h04, 8'h00, 8'hC3);
    chk("R10", "izpy write ptr reads", {tr_rd[1], tr_rd[2], tr_wr[1], tr_wr[2]}, 4'b1100);
    chk("R10", "izpy write cycle", {tr_wr[3], tr_rd[3], tr_addr[3], tr_wd[3]},
        {2'b10, p, 8'hC3});
  endtask

  task automatic t_busy();
    @(negedge clk);
    mode = 4'd6; wr = 0; op1 = 8'h40; start = 1'b1;
    @(negedge clk);
    chk("R11", "first ptr fetch", mem_addr, 16'h0040);
    mode = 4'd3; op1 = 8'h90;
    @(negedge clk);
    start = 1'b0;
    chk("R11", "busy start ignored", mem_addr, 16'h0041);
    @(negedge clk);
    chk("R11", "data addr kept", mem_addr, {memf(16'h0041), memf(16'h0040)});
    @(negedge clk);
    chk("R11", "done after ignored start", done, 1);
    chk("R11", "result kept", rdata, memf({memf(16'h0041), memf(16'h0040)}));
    @(negedge clk);
    chk("R11", "no extra op", {done, mem_rd}, 2'b00);
  endtask

  task automatic t_b2b();
    @(negedge clk);
    mode = 4'd2; wr = 0; op1 = 8'h5E; start = 1'b1;
    @(negedge clk);
    chk("R2", "first done", done, 1);
    chk("R2", "first value", rdata, 8'h5E);
    mode = 4'd3; op1 = 8'h33;
    @(negedge clk);
    start = 1'b0;
    chk("R11", "start in done cycle taken", {mem_rd, mem_addr}, {1'b1, 16'h0033});
    chk("R11", "value held", rdata, 8'h5E);
    @(negedge clk);
    chk("R4", "second done", {done, rdata}, {1'b1, memf(16'h0033)});
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; mode = '0; wr = 0; op1 = '0; op2 = '0;
    idx_x = '0; idx_y = '0; acc_in = '0; wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_imm();
    t_acc();
    t_zp();
    t_abs();
    t_indirect(4'd6, "R6", 8'hFF, 8'h00, 8'h00);
    t_indirect(4'd6, "R6", 8'h37, 8'h00, 8'h00);
    t_indirect(4'd7, "R7", 8'h80, 8'h90, 8'h00);
    t_indirect(4'd7, "R7", 8'hF0, 8'h0F, 8'h00);
    t_indirect(4'd8, "R8", 8'h20, 8'h00, 8'hFF);
    t_err();
    t_write();
    t_busy();
    t_b2b();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule